// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block is a watchdog timer on a simple memory-mapped register bus. Software arms it by writing a mode word that holds an enable bit and a 4-bit interval code. It must then keep restarting the countdown before the interval runs out. If it does not, the block either drives a system reset pulse or raises a sticky interrupt. A configuration word selects which of the two happens.

The mode and configuration words are guarded by a 16-bit key in their upper half. A write without the key leaves the stored state unchanged. Restarting the count needs a fixed pattern written to the control word, so a stray write does not keep a hung system alive. Time advances through a single-cycle half-second tick input, which stands in for the slow timing base. The interval codes map to a table of uneven steps, from half a second up to sixteen seconds.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the watchdog is disabled with interval code 0 and expiry action 01, `sys_rst_o` and `irq_o` are low, and reading mode returns 0 while reading configuration returns 0x00000001.
- R2: Writes to the mode word (offset 0x18) and to the configuration word (offset 0x14) are accepted only when write data bits 31:16 equal 0x16AA. Any other write to these offsets leaves the stored contents unchanged.
- R3: A write to the control word (offset 0x10) with bit 0 set and 0xA57 in bits 12:1 (data 0x000014AF) restarts the countdown from zero. Any other control value has no effect on the count.
- R4: Mode bit 0 enables counting. While it is clear, ticks are ignored and no expiry occurs. Writing only the key to mode stops the watchdog.
- R5: Mode bits 7:4 hold the interval code. The interval in half-second ticks is 1 for code 0, twice the code for codes 1 to 6, then 16, 20, 24 and 28 for codes 7 to 10, and 32 for codes 11 to 15. Expiry happens on the edge that samples the last tick of the interval.
- R6: Every accepted mode write restarts the countdown, so a new interval is counted from zero.
- R7: Configuration bits 1:0 select the expiry action. Value 10 selects interrupt only. Values 00, 01 and 11 drive `sys_rst_o` high for exactly RST_CYCLES (16) clock cycles. Ticks are ignored during the pulse, and counting restarts from zero once it ends.
- R8: In interrupt mode an expiry sets a sticky pending bit, which drives `irq_o` and reads back in configuration bit 8. The count restarts after the expiry. A keyed configuration write with bit 8 set clears the pending bit. When an expiry and a clear fall in the same cycle, the bit stays set.
- R9: A read is registered and appears on `bus_rdata` one cycle after `bus_rd`. Mode reads as {24'b0, code, 3'b0, enable}, configuration as {23'b0, pending, 6'b0, action}, and control as 0. The key field always reads as zero.
- R10: A valid restart in the same cycle as the tick that would complete the interval wins: no expiry occurs and the count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_half_sec | input | 1 | Single-cycle pulse every half second |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sys_rst_o | output | 1 | System reset pulse on expiry |
| irq_o | output | 1 | Sticky expiry interrupt |

## Verification
Two pairs of events can land on the same clock edge, and the bench provokes each by driving both inputs in one cycle. In the first pair, the final tick of an interval meets a valid restart write. The judgement there is that no reset pulse appears and that a full interval is counted again afterwards. In the second pair, an interrupt-mode expiry meets a keyed write that clears the pending bit. The judgement there is that `irq_o` stays high after that edge and that a later clear with no tick pending does lower it.

// File: rtl/wdog_keyed_pkg.sv
`timescale 1ns/1ps
package wdog_keyed_pkg;
  localparam logic [15:0] KEY_VAL     = 16'h16AA;
  localparam logic [11:0] RESTART_PAT = 12'hA57;
  localparam int          OFS_CTRL    = 'h10;
  localparam int          OFS_CFG     = 'h14;
  localparam int          OFS_MODE    = 'h18;
  localparam int          PEND_BIT    = 8;

  typedef enum logic [1:0] {
    ACT_RST_A = 2'b00,
    ACT_RST   = 2'b01,
    ACT_IRQ   = 2'b10,
    ACT_RST_B = 2'b11
  } act_t;

  // interval length in half-second ticks for an interval code
  function automatic int half_ticks(input int code);
    if (code == 0)       return 1;
    else if (code <= 6)  return 2 * code;
    else if (code <= 11) return 4 * code - 12;
    else                 return 32;
  endfunction
endpackage

// File: rtl/wdog_keyed_regs.sv
`timescale 1ns/1ps
module wdog_keyed_regs
  import wdog_keyed_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              irq_hit,
  output logic              kick,
  output logic              mode_wr,
  output logic              mode_en,
  output logic [CODE_W-1:0] mode_code,
  output act_t              action,
  output logic              irq_pend,
  output logic [31:0]       bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);

  logic key_ok;
  logic cfg_wr;
  logic pend_clr;
  logic unused_bits;
  logic [31:0] rd_mux;

  assign key_ok   = (bus_wdata[31:16] == KEY_VAL);
  assign kick     = bus_wr && (bus_addr == A_CTRL) && bus_wdata[0]
                    && (bus_wdata[12:1] == RESTART_PAT);
  assign mode_wr  = bus_wr && (bus_addr == A_MODE) && key_ok;
  assign cfg_wr   = bus_wr && (bus_addr == A_CFG) && key_ok;
  assign pend_clr = cfg_wr && bus_wdata[PEND_BIT];
  assign unused_bits = ^bus_wdata[15:13];

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_MODE: begin
        rd_mux[0]             = mode_en;
        rd_mux[4 +: CODE_W]   = mode_code;
      end
      A_CFG: begin
        rd_mux[1:0]           = action;
        rd_mux[PEND_BIT]      = irq_pend;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_en   <= 1'b0;
      mode_code <= '0;
      action    <= ACT_RST;
      irq_pend  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (mode_wr) begin
        mode_en   <= bus_wdata[0];
        mode_code <= bus_wdata[4 +: CODE_W];
      end
      if (cfg_wr) action <= act_t'(bus_wdata[1:0]);
      if (irq_hit)       irq_pend <= 1'b1;
      else if (pend_clr) irq_pend <= 1'b0;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/wdog_keyed_interval.sv
`timescale 1ns/1ps
module wdog_keyed_interval
  import wdog_keyed_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 6
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  limit
);
  always_comb limit = CNT_W'(half_ticks(int'(code)));
endmodule

// File: rtl/wdog_keyed_counter.sv
`timescale 1ns/1ps
module wdog_keyed_counter
  import wdog_keyed_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  input  act_t             action,
  output logic             irq_hit,
  output logic             sys_rst_o
);
  localparam int LEFT_W = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;

  logic [CNT_W-1:0]  cnt;
  logic [LEFT_W-1:0] left;
  logic              fire;
  logic              rst_fire;

  assign fire = !sys_rst_o && !restart && en && tick
                && (({1'b0, cnt} + 1'b1) >= {1'b0, limit});
  assign irq_hit  = fire && (action == ACT_IRQ);
  assign rst_fire = fire && (action != ACT_IRQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      left      <= '0;
      sys_rst_o <= 1'b0;
    end else if (sys_rst_o) begin
      cnt <= '0;
      if (left == '0) sys_rst_o <= 1'b0;
      else            left <= left - 1'b1;
    end else if (restart) begin
      cnt <= '0;
    end else if (fire) begin
      cnt <= '0;
      if (rst_fire) begin
        sys_rst_o <= 1'b1;
        left      <= LEFT_W'(RST_CYCLES - 1);
      end
    end else if (en && tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_keyed.sv
`timescale 1ns/1ps
module wdog_keyed
  import wdog_keyed_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CODE_W     = 4,
  parameter int CNT_W      = 6,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_half_sec,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_rst_o,
  output logic              irq_o
);
  logic              kick;
  logic              mode_wr;
  logic              mode_en;
  logic [CODE_W-1:0] mode_code;
  act_t              action;
  logic              irq_hit;
  logic              irq_pend;
  logic [CNT_W-1:0]  limit;

  wdog_keyed_regs #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_hit(irq_hit),
    .kick(kick), .mode_wr(mode_wr), .mode_en(mode_en),
    .mode_code(mode_code), .action(action), .irq_pend(irq_pend),
    .bus_rdata(bus_rdata)
  );

  wdog_keyed_interval #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_interval (
    .code(mode_code), .limit(limit)
  );

  wdog_keyed_counter #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_counter (
    .clk(clk), .rst(rst), .tick(tick_half_sec), .en(mode_en),
    .restart(kick | mode_wr), .limit(limit), .action(action),
    .irq_hit(irq_hit), .sys_rst_o(sys_rst_o)
  );

  assign irq_o = irq_pend;
endmodule

// File: rtl/wdog_keyed_chk.sv
`timescale 1ns/1ps
module wdog_keyed_chk
  import wdog_keyed_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CODE_W     = 4,
  parameter int RST_CYCLES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              mode_en,
  input logic [CODE_W-1:0] mode_code,
  input act_t              action,
  input logic              sys_rst_o,
  input logic              irq_o
);
  localparam int RUN_W = $clog2(RST_CYCLES + 1) + 1;
  logic [RUN_W-1:0] run;
  logic bad_mode_wr;
  logic pend_clear;

  assign bad_mode_wr = bus_wr && (bus_addr == ADDR_W'(OFS_MODE))
                       && (bus_wdata[31:16] != KEY_VAL);
  assign pend_clear  = bus_wr && (bus_addr == ADDR_W'(OFS_CFG))
                       && (bus_wdata[31:16] == KEY_VAL) && bus_wdata[PEND_BIT];

  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else     run <= sys_rst_o ? run + 1'b1 : '0;
  end

  p_rst_len_r7: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> (run < RUN_W'(RST_CYCLES)));
  p_rst_end_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_o) |-> ($past(run) == RUN_W'(RST_CYCLES - 1)));
  p_rst_action_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> ($past(action) != ACT_IRQ));
  p_key_gate_r2: assert property (@(posedge clk) disable iff (rst)
    bad_mode_wr |=> ($stable(mode_en) && $stable(mode_code)));
  p_no_fire_off_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(sys_rst_o) || $rose(irq_o)) |-> $past(mode_en));
  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !pend_clear) |=> irq_o);
  p_irq_action_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(action) == ACT_IRQ));
endmodule

bind wdog_keyed wdog_keyed_chk #(
  .ADDR_W(ADDR_W), .CODE_W(CODE_W), .RST_CYCLES(RST_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .mode_en(mode_en), .mode_code(mode_code),
  .action(action), .sys_rst_o(sys_rst_o), .irq_o(irq_o)
);

// File: tb/wdog_keyed_bench.sv
`timescale 1ns/1ps
module wdog_keyed_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RSTC       = 16;
  localparam logic [7:0] A_CTRL = 8'h10;
  localparam logic [7:0] A_CFG  = 8'h14;
  localparam logic [7:0] A_MODE = 8'h18;
  localparam logic [31:0] KEY   = 32'h16AA_0000;
  localparam logic [31:0] MAGIC = 32'h0000_14AF;

  typedef struct {
    string       req;
    bit          c_rst;
    bit          e_rst;
    bit          c_irq;
    bit          e_irq;
    bit          c_rd;
    logic [31:0] e_rd;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_half_sec = 1'b0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic sys_rst_o;
  logic irq_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_keyed u_wdog_keyed (
    .clk(clk), .rst(rst), .tick_half_sec(tick_half_sec),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst_o(sys_rst_o), .irq_o(irq_o)
  );

  // monitor: one expected item per edge, compared just after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      if (it.c_rst) begin
        total++;
        if (sys_rst_o !== it.e_rst) begin
          bad++;
          $display("FAIL %s sys_rst_o actual=%0b expected=%0b", it.req, sys_rst_o, it.e_rst);
        end
      end
      if (it.c_irq) begin
        total++;
        if (irq_o !== it.e_irq) begin
          bad++;
          $display("FAIL %s irq_o actual=%0b expected=%0b", it.req, irq_o, it.e_irq);
        end
      end
      if (it.c_rd) begin
        total++;
        if (bus_rdata !== it.e_rd) begin
          bad++;
          $display("FAIL %s bus_rdata actual=%h expected=%h", it.req, bus_rdata, it.e_rd);
        end
      end
    end
  end

  task automatic drv(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     input logic rd, input logic tk);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; bus_rd = rd; tick_half_sec = tk;
  endtask

  task automatic push(input string req, input bit cr, input bit er,
                      input bit ci, input bit ei, input bit cd, input logic [31:0] ed);
    exp_t it;
    it.req = req; it.c_rst = cr; it.e_rst = er; it.c_irq = ci; it.e_irq = ei;
    it.c_rd = cd; it.e_rd = ed;
    q.push_back(it);
  endtask

  task automatic idle(); drv(1'b0, 8'h0, 32'h0, 1'b0, 1'b0); endtask
  task automatic tick(); drv(1'b0, 8'h0, 32'h0, 1'b0, 1'b1); endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d); drv(1'b1, a, d, 1'b0, 1'b0); endtask
  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] e);
    drv(1'b0, a, 32'h0, 1'b1, 1'b0); push(req, 0, 0, 0, 0, 1, e);
  endtask
  task automatic exp_rst(input string req, input bit v); push(req, 1, v, 0, 0, 0, 0); endtask
  task automatic exp_irq(input string req, input bit v); push(req, 1, 0, 1, v, 0, 0); endtask

  task automatic pulse_chk(input string req);
    for (int i = 0; i < RSTC - 1; i++) begin idle(); exp_rst(req, 1'b1); end
    idle(); exp_rst(req, 1'b0);
  endtask

  function automatic int lim(input int code);
    case (code)
      0: return 1;
      1, 2, 3, 4, 5, 6: return 2 * code;
      7: return 16;
      8: return 20;
      9: return 24;
      10: return 28;
      default: return 32;
    endcase
  endfunction

  task automatic run_interval(input string req, input int code);
    wr(A_MODE, KEY | 32'(code << 4) | 32'h1);
    for (int i = 0; i < lim(code) - 1; i++) begin tick(); exp_rst(req, 1'b0); end
    tick(); exp_rst(req, 1'b1);
    pulse_chk("R7 pulse length");
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    idle(); push("R1 outputs after reset", 1, 0, 1, 0, 0, 0);
    rd_chk("R1 mode after reset", A_MODE, 32'h0);
    rd_chk("R1 cfg after reset", A_CFG, 32'h1);
    // R2 writes without key are ignored
    wr(A_MODE, 32'h0000_0031);
    rd_chk("R2 mode keyless write ignored", A_MODE, 32'h0);
    wr(A_CFG, 32'h1234_0002);
    rd_chk("R2 cfg wrong key ignored", A_CFG, 32'h1);
    // R4 disabled: ticks ignored
    for (int i = 0; i < 3; i++) begin tick(); exp_rst("R4 disabled no expiry", 1'b0); end
    // R9 read formatting, control reads zero
    wr(A_MODE, KEY | 32'h31);
    rd_chk("R9 mode readback key zero", A_MODE, 32'h31);
    rd_chk("R9 control reads zero", A_CTRL, 32'h0);
    // R5 interval table
    run_interval("R5 code 0", 0);
    run_interval("R5 code 1", 1);
    run_interval("R5 code 5", 5);
    run_interval("R5 code 7", 7);
    run_interval("R5 code 8", 8);
    run_interval("R5 code 10", 10);
    run_interval("R5 code 11", 11);
    run_interval("R5 code 15", 15);
    // R3 valid restart
    wr(A_MODE, KEY | 32'h31);
    for (int i = 0; i < 5; i++) begin tick(); exp_rst("R3 before kick", 1'b0); end
    wr(A_CTRL, MAGIC); exp_rst("R3 kick", 1'b0);
    for (int i = 0; i < 5; i++) begin tick(); exp_rst("R3 after kick", 1'b0); end
    tick(); exp_rst("R3 expiry after kick", 1'b1);
    pulse_chk("R7 pulse length");
    // R3 invalid control values ignored
    wr(A_MODE, KEY | 32'h31);
    for (int i = 0; i < 5; i++) begin tick(); exp_rst("R3 prep", 1'b0); end
    wr(A_CTRL, 32'h0000_14AE); exp_rst("R3 bit0 clear ignored", 1'b0);
    wr(A_CTRL, 32'h0000_14AD); exp_rst("R3 bad pattern ignored", 1'b0);
    tick(); exp_rst("R3 count not restarted", 1'b1);
    pulse_chk("R7 pulse length");
    // R6 mode write restarts
    wr(A_MODE, KEY | 32'h31);
    for (int i = 0; i < 4; i++) begin tick(); exp_rst("R6 prep", 1'b0); end
    wr(A_MODE, KEY | 32'h31); exp_rst("R6 mode rewrite", 1'b0);
    for (int i = 0; i < 5; i++) begin tick(); exp_rst("R6 fresh count", 1'b0); end
    tick(); exp_rst("R6 expiry after fresh count", 1'b1);
    pulse_chk("R7 pulse length");
    // R10 restart collides with final tick
    wr(A_MODE, KEY | 32'h11);
    tick(); exp_rst("R10 first tick", 1'b0);
    drv(1'b1, A_CTRL, MAGIC, 1'b0, 1'b1); exp_rst("R10 restart wins", 1'b0);
    tick(); exp_rst("R10 recount", 1'b0);
    tick(); exp_rst("R10 expiry after recount", 1'b1);
    pulse_chk("R7 pulse length");
    // R7/R8 interrupt mode
    wr(A_CFG, KEY | 32'h2);
    wr(A_MODE, KEY | 32'h01);
    tick(); push("R8 irq expiry", 1, 0, 1, 1, 0, 0);
    rd_chk("R8 pending readback", A_CFG, 32'h102);
    tick(); push("R8 irq again no reset", 1, 0, 1, 1, 0, 0);
    wr(A_CFG, 32'h0000_0102); exp_irq("R8 keyless clear ignored", 1'b1);
    wr(A_CFG, KEY | 32'h102); exp_irq("R8 keyed clear", 1'b0);
    drv(1'b1, A_CFG, KEY | 32'h102, 1'b0, 1'b1); exp_irq("R8 set wins over clear", 1'b1);
    wr(A_CFG, KEY | 32'h102); exp_irq("R8 clear after collision", 1'b0);
    // R4 stop by key-only write
    wr(A_MODE, KEY);
    for (int i = 0; i < 3; i++) begin tick(); exp_irq("R4 stopped no expiry", 1'b0); end
    rd_chk("R4 mode after stop", A_MODE, 32'h0);
    // return to reset action
    wr(A_CFG, KEY | 32'h1);
    rd_chk("R7 action back to reset", A_CFG, 32'h1);
    idle(); idle();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule